// File: doc/BRIEF.md
# Tagged Memory Store Controller

This block sits on the store side of a byte-addressed data memory that carries one validity tag for every 32-byte granule. It takes one store request per cycle and turns it into a data-memory write (granule address, byte enables, lane-aligned data) together with a tag-memory write for the same granule. Both writes leave the block on the same clock edge.

There are four request kinds. A plain data store writes 1, 2, 4 or 8 bytes and always clears the granule's tag. A conditional data store does the same, but only while the load-link reservation flag is set. A capability store writes the whole granule and stores a tag byte whose bit 0 is the supplied tag bit. A conditional capability store does that only while the reservation flag is set.

Conditional kinds return a zero-extended success value. A store that performs a write drops the reservation, so a second conditional store fails until the flag is set again. A misaligned request is rejected with an error flag and writes nothing.

Top module: `tagged_store_ctrl`

## Requirements
- R1: A data store (kind code 0) of size code 0, 1, 2 or 3 writes 1, 2, 4 or 8 bytes. It uses the low 8, 16, 32 or 64 bits of the data input, placed in the byte lanes starting at address offset addr[4:0] inside the 32-byte granule. Byte enable bit i marks lane i, and the data-memory address is the request address with bits [4:0] cleared.
- R2: Every write that is not a capability write also writes tag byte 0x00, in the same cycle, to a tag address equal to the request address with bits [4:0] cleared.
- R3: A conditional store (kind 1 or 3) made while the reservation flag is clear writes neither memory and returns result 0.
- R4: A conditional data store (kind 1) made while the reservation flag is set performs the R1/R2 writes and returns result 1.
- R5: A capability store (kind 2) writes all 32 bytes, with every byte enable set, and writes the tag byte {7'b0, tag bit}.
- R6: A conditional capability store (kind 3) performs the R5 writes and returns 1 only when the reservation flag is set.
- R7: A request is misaligned when its address is not a multiple of its size (32 bytes for kinds 2 and 3). A misaligned request raises the error flag, performs no data or tag write, and leaves the reservation flag unchanged.
- R8: The reservation-set input sets the flag. A store that writes clears it. When both happen in the same cycle, the set wins.
- R9: A request accepted on one clock edge produces its writes and its one-cycle response on the next edge. Request-ready is always high. In a cycle with no write, the write address, enables, data and tag byte are all zero. Non-conditional kinds return result 0.
- R10: Under reset, all write enables, the response, the error flag and the reservation flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_kind | input | 2 | 0 data, 1 conditional data, 2 capability, 3 conditional capability |
| req_size | input | 2 | Data store size code: 1, 2, 4 or 8 bytes |
| req_addr | input | 64 | Byte address |
| req_data | input | 64 | Source value for data stores |
| req_cap_data | input | 256 | Granule contents for capability stores |
| req_cap_tag | input | 1 | Tag bit for capability stores |
| ll_set | input | 1 | Set the reservation flag |
| dmem_we | output | 1 | Data-memory write strobe |
| dmem_addr | output | 64 | Granule-aligned write address |
| dmem_be | output | 32 | Per-byte enables within the granule |
| dmem_wdata | output | 256 | Lane-aligned write data |
| tag_we | output | 1 | Tag-memory write strobe |
| tag_addr | output | 64 | Granule-aligned tag address |
| tag_wdata | output | 8 | Tag byte |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_err | output | 1 | Request was misaligned |
| rsp_result | output | 64 | Zero-extended conditional success |
| ll_flag | output | 1 | Reservation flag |

## Verification
The embedded properties assume that reset is held low from the start, and that the request inputs are known whenever req_valid is high. They do not assume that requests are aligned or that the reservation is in any particular state, because the block itself must reject or refuse those cases. The stimulus drives every field to a defined value on each cycle, including idle ones. It deliberately covers misaligned addresses, conditional stores with and without a reservation, and a reservation set that coincides with a store.

// File: rtl/tsc_pkg.sv
// Shared encodings for the tagged store controller.
// Assumes: kind codes are fixed by the request interface.
package tsc_pkg;
    typedef enum logic [1:0] {
        KIND_DATA      = 2'd0,
        KIND_DATA_COND = 2'd1,
        KIND_CAP       = 2'd2,
        KIND_CAP_COND  = 2'd3
    } store_kind_e;

    localparam int unsigned TAG_BYTE_W = 8;
endpackage

// File: rtl/tsc_decode.sv
// Combinational decode of one store request: alignment, permission,
// byte enables, lane-placed write data and the tag byte.
// Assumes: data stores are at most 8 bytes wide and fit in one granule.
module tsc_decode #(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned GRAN_BYTES = 32,
    localparam int unsigned OFS_W     = $clog2(GRAN_BYTES),
    localparam int unsigned CAP_W     = GRAN_BYTES * 8
) (
    input  logic [1:0]             kind,
    input  logic [1:0]             size,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      data,
    input  logic [CAP_W-1:0]       cap_data,
    input  logic                   cap_tag,
    input  logic                   ll_flag,
    output logic                   misaligned,
    output logic                   permit,
    output logic                   is_cond,
    output logic [ADDR_W-1:0]      gran_addr,
    output logic [GRAN_BYTES-1:0]  be,
    output logic [CAP_W-1:0]       wdata,
    output logic [tsc_pkg::TAG_BYTE_W-1:0] tag_byte
);
    logic                  is_cap;
    logic [OFS_W-1:0]      ofs;
    logic [OFS_W:0]        nbytes;
    logic [7:0]            dshift;
    logic [DATA_W-1:0]     dmask;
    logic [GRAN_BYTES-1:0] lowbe;

    assign is_cap    = kind[1];
    assign is_cond   = kind[0];
    assign ofs       = addr[OFS_W-1:0];
    assign gran_addr = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

    // Access size in bytes for this request.
    always_comb begin
        if (is_cap) nbytes = (OFS_W+1)'(GRAN_BYTES);
        else        nbytes = (OFS_W+1)'(1) << size;
    end

    // Alignment and permission: conditionals need the reservation.
    always_comb begin
        misaligned = (({1'b0, ofs}) & (nbytes - (OFS_W+1)'(1))) != '0;
        permit     = !misaligned && (!is_cond || ll_flag);
    end

    // Byte-enable and data placement within the granule.
    always_comb begin
        dshift = 8'd8 << size;
        dmask  = ~({DATA_W{1'b1}} << dshift);
        lowbe  = ~({GRAN_BYTES{1'b1}} << nbytes);
        if (is_cap) begin
            be       = '1;
            wdata    = cap_data;
            tag_byte = {{(tsc_pkg::TAG_BYTE_W-1){1'b0}}, cap_tag};
        end else begin
            be       = lowbe << ofs;
            wdata    = CAP_W'(data & dmask) << {ofs, 3'b000};
            tag_byte = '0;
        end
    end
endmodule

// File: rtl/tsc_llflag.sv
// Load-link reservation flag. Set by ll_set, cleared by any store that
// writes; a same-cycle set takes priority.
// Assumes: store_wrote is asserted only for an accepted, performed write.
module tsc_llflag (
    input  logic clk,
    input  logic rst_n,
    input  logic ll_set,
    input  logic store_wrote,
    output logic ll_q
);
    // Reservation register update.
    always_ff @(posedge clk) begin
        if (!rst_n)           ll_q <= 1'b0;
        else if (ll_set)      ll_q <= 1'b1;
        else if (store_wrote) ll_q <= 1'b0;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ll_set |=> ll_q);
    assert_write_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (store_wrote && !ll_set) |=> !ll_q);
endmodule

// File: rtl/tsc_outreg.sv
// Output register stage: launches data and tag writes together and the
// one-cycle response. Idle write fields are held at zero.
// Assumes: inputs come from tsc_decode in the same cycle.
module tsc_outreg #(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned GRAN_BYTES = 32,
    localparam int unsigned OFS_W     = $clog2(GRAN_BYTES),
    localparam int unsigned CAP_W     = GRAN_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid,
    input  logic                  misaligned,
    input  logic                  permit,
    input  logic                  is_cond,
    input  logic [ADDR_W-1:0]     gran_addr,
    input  logic [GRAN_BYTES-1:0] be,
    input  logic [CAP_W-1:0]      wdata,
    input  logic [tsc_pkg::TAG_BYTE_W-1:0] tag_byte,
    output logic                  dmem_we,
    output logic [ADDR_W-1:0]     dmem_addr,
    output logic [GRAN_BYTES-1:0] dmem_be,
    output logic [CAP_W-1:0]      dmem_wdata,
    output logic                  tag_we,
    output logic [ADDR_W-1:0]     tag_addr,
    output logic [tsc_pkg::TAG_BYTE_W-1:0] tag_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [DATA_W-1:0]     rsp_result
);
    logic wr;
    assign wr = valid && permit;

    // Data-memory write port register.
    always_ff @(posedge clk) begin
        if (!rst_n || !wr) begin
            dmem_we    <= 1'b0;
            dmem_addr  <= '0;
            dmem_be    <= '0;
            dmem_wdata <= '0;
        end else begin
            dmem_we    <= 1'b1;
            dmem_addr  <= gran_addr;
            dmem_be    <= be;
            dmem_wdata <= wdata;
        end
    end

    // Tag-memory write port register, launched with the data write.
    always_ff @(posedge clk) begin
        if (!rst_n || !wr) begin
            tag_we    <= 1'b0;
            tag_addr  <= '0;
            tag_wdata <= '0;
        end else begin
            tag_we    <= 1'b1;
            tag_addr  <= gran_addr;
            tag_wdata <= tag_byte;
        end
    end

    // Response register: error and zero-extended conditional success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_result <= '0;
        end else begin
            rsp_valid  <= valid;
            rsp_err    <= valid && misaligned;
            rsp_result <= DATA_W'(valid && is_cond && permit);
        end
    end

    assert_tag_with_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we == tag_we);
    assert_tag_addr_gran_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |-> (tag_addr == dmem_addr && tag_addr[OFS_W-1:0] == '0));
    assert_tag_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |-> (tag_wdata[tsc_pkg::TAG_BYTE_W-1:1] == '0));
    assert_err_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!dmem_we && !tag_we && rsp_result == '0));
    assert_result_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_result[DATA_W-1:1] == '0);
    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (!rsp_valid && !dmem_we));
endmodule

// File: rtl/tagged_store_ctrl.sv
// Tagged memory store controller top. Decodes one request per cycle,
// issues a data write plus a matching tag write, and keeps the
// load-link reservation flag for conditional stores.
// Assumes: downstream memories accept one write per cycle.
module tagged_store_ctrl #(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned GRAN_BYTES = 32,
    localparam int unsigned CAP_W     = GRAN_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_kind,
    input  logic [1:0]            req_size,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_data,
    input  logic [CAP_W-1:0]      req_cap_data,
    input  logic                  req_cap_tag,
    input  logic                  ll_set,
    output logic                  dmem_we,
    output logic [ADDR_W-1:0]     dmem_addr,
    output logic [GRAN_BYTES-1:0] dmem_be,
    output logic [CAP_W-1:0]      dmem_wdata,
    output logic                  tag_we,
    output logic [ADDR_W-1:0]     tag_addr,
    output logic [7:0]            tag_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [DATA_W-1:0]     rsp_result,
    output logic                  ll_flag
);
    logic                  misaligned, permit, is_cond;
    logic [ADDR_W-1:0]     gran_addr;
    logic [GRAN_BYTES-1:0] be;
    logic [CAP_W-1:0]      wdata;
    logic [7:0]            tag_byte;

    assign req_ready = 1'b1;

    tsc_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN_BYTES(GRAN_BYTES)) u_dec (
        .kind(req_kind), .size(req_size), .addr(req_addr), .data(req_data),
        .cap_data(req_cap_data), .cap_tag(req_cap_tag), .ll_flag(ll_flag),
        .misaligned(misaligned), .permit(permit), .is_cond(is_cond),
        .gran_addr(gran_addr), .be(be), .wdata(wdata), .tag_byte(tag_byte)
    );

    tsc_llflag u_ll (
        .clk(clk), .rst_n(rst_n), .ll_set(ll_set),
        .store_wrote(req_valid && permit), .ll_q(ll_flag)
    );

    tsc_outreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN_BYTES(GRAN_BYTES)) u_out (
        .clk(clk), .rst_n(rst_n), .valid(req_valid), .misaligned(misaligned),
        .permit(permit), .is_cond(is_cond), .gran_addr(gran_addr), .be(be),
        .wdata(wdata), .tag_byte(tag_byte),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_be(dmem_be),
        .dmem_wdata(dmem_wdata), .tag_we(tag_we), .tag_addr(tag_addr),
        .tag_wdata(tag_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_result(rsp_result)
    );

    assert_cond_fail_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind[0] && !ll_flag) |=> (!dmem_we && rsp_result == '0));
    assert_cap_full_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind[1] && req_addr[4:0] == '0 && !req_kind[0]) |=> (dmem_be == '1));
endmodule

// File: tb/tagged_store_ctrl_tb.sv
module tagged_store_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_kind = '0;
    logic [1:0]   req_size = '0;
    logic [63:0]  req_addr = '0;
    logic [63:0]  req_data = '0;
    logic [255:0] req_cap_data = '0;
    logic         req_cap_tag = 1'b0;
    logic         ll_set = 1'b0;
    logic         dmem_we, tag_we, rsp_valid, rsp_err, ll_flag;
    logic [63:0]  dmem_addr, tag_addr, rsp_result;
    logic [31:0]  dmem_be;
    logic [255:0] dmem_wdata;
    logic [7:0]   tag_wdata;

    int checks = 0;
    int errors = 0;
    bit ll_m = 1'b0;

    always #5 clk = ~clk;

    tagged_store_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_size(req_size), .req_addr(req_addr),
        .req_data(req_data), .req_cap_data(req_cap_data), .req_cap_tag(req_cap_tag),
        .ll_set(ll_set), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_be(dmem_be), .dmem_wdata(dmem_wdata), .tag_we(tag_we),
        .tag_addr(tag_addr), .tag_wdata(tag_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_result(rsp_result), .ll_flag(ll_flag)
    );

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] cap_pat(input logic [63:0] s);
        return {s ^ 64'hA5A5_0000_FFFF_1234, ~s, s + 64'd77, s};
    endfunction

    // One cycle of the reference model: drive, predict, clock, compare.
    task automatic step(input logic v, input logic [1:0] k, input logic [1:0] s,
                        input logic [63:0] a, input logic [63:0] d,
                        input logic [255:0] c, input logic t, input logic ls,
                        input string req);
        int n, ofs;
        bit mis, cond, wr;
        logic [31:0]  e_be;
        logic [255:0] e_wd;
        logic [63:0]  e_addr;
        logic [7:0]   e_tag;
        req_valid = v; req_kind = k; req_size = s; req_addr = a;
        req_data = d; req_cap_data = c; req_cap_tag = t; ll_set = ls;
        n    = k[1] ? 32 : (1 << s);
        ofs  = int'(a % 64'd32);
        mis  = (a % 64'(n)) != 0;
        cond = k[0];
        wr   = v && !mis && (!cond || ll_m);
        e_be = '0; e_wd = '0; e_addr = '0; e_tag = '0;
        if (wr) begin
            e_addr = a - 64'(ofs);
            if (k[1]) begin
                e_be = '1; e_wd = c; e_tag = {7'b0, t};
            end else begin
                for (int i = 0; i < 32; i++) begin
                    if (i >= ofs && i < ofs + n) begin
                        e_be[i] = 1'b1;
                        e_wd[i*8 +: 8] = d[(i-ofs)*8 +: 8];
                    end
                end
            end
        end
        if (ls) ll_m = 1'b1;
        else if (wr) ll_m = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(req, "ready",  {255'b0, req_ready}, 256'd1);
        chk(req, "dmem_we", {255'b0, dmem_we}, {255'b0, wr});
        chk(req, "tag_we",  {255'b0, tag_we},  {255'b0, wr});
        chk(req, "dmem_addr", {192'b0, dmem_addr}, {192'b0, e_addr});
        chk(req, "tag_addr",  {192'b0, tag_addr},  {192'b0, e_addr});
        chk(req, "dmem_be",   {224'b0, dmem_be},   {224'b0, e_be});
        chk(req, "dmem_wdata", dmem_wdata, e_wd);
        chk(req, "tag_wdata", {248'b0, tag_wdata}, {248'b0, e_tag});
        chk(req, "rsp_valid", {255'b0, rsp_valid}, {255'b0, v});
        chk(req, "rsp_err",   {255'b0, rsp_err},   {255'b0, v && mis});
        chk(req, "rsp_result", {192'b0, rsp_result}, {255'b0, v && cond && wr});
        chk(req, "ll_flag",   {255'b0, ll_flag},   {255'b0, ll_m});
    endtask

    task automatic idle(input string req);
        step(1'b0, 2'd0, 2'd0, 64'd0, 64'd0, 256'd0, 1'b0, 1'b0, req);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "dmem_we", {255'b0, dmem_we}, 256'd0);
        chk("R10", "tag_we", {255'b0, tag_we}, 256'd0);
        chk("R10", "rsp_valid", {255'b0, rsp_valid}, 256'd0);
        chk("R10", "rsp_err", {255'b0, rsp_err}, 256'd0);
        chk("R10", "ll_flag", {255'b0, ll_flag}, 256'd0);
        rst_n = 1'b1;
        idle("R9");

        // R1 R2: every size at every aligned offset of one granule
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 32; o += (1 << s)) begin
                step(1'b1, 2'd0, 2'(s), 64'h0000_1234_5678_9A00 + 64'(o),
                     64'hF1E2_D3C4_B5A6_9788 ^ 64'(o * 3 + s), 256'd0, 1'b1, 1'b0, "R1");
            end
        end
        step(1'b1, 2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFE8, 64'h0123_4567_89AB_CDEF,
             256'd0, 1'b0, 1'b0, "R2");
        idle("R9");

        // R7: misaligned data and capability stores
        step(1'b1, 2'd0, 2'd1, 64'h101, 64'h1111, 256'd0, 1'b0, 1'b0, "R7");
        step(1'b1, 2'd0, 2'd3, 64'h104, 64'h2222, 256'd0, 1'b0, 1'b0, "R7");
        step(1'b1, 2'd2, 2'd0, 64'h108, 64'd0, cap_pat(64'h9), 1'b1, 1'b0, "R7");

        // R3: conditional with flag clear
        step(1'b1, 2'd1, 2'd2, 64'h200, 64'hDEAD_BEEF, 256'd0, 1'b0, 1'b0, "R3");
        step(1'b1, 2'd3, 2'd0, 64'h220, 64'd0, cap_pat(64'h5), 1'b1, 1'b0, "R3");

        // R4 R8: set, succeed, second fails
        step(1'b0, 2'd0, 2'd0, 64'd0, 64'd0, 256'd0, 1'b0, 1'b1, "R8");
        step(1'b1, 2'd1, 2'd2, 64'h204, 64'hCAFE_F00D, 256'd0, 1'b0, 1'b0, "R4");
        step(1'b1, 2'd1, 2'd2, 64'h204, 64'hCAFE_F00D, 256'd0, 1'b0, 1'b0, "R8");

        // R8: plain store drops reservation
        step(1'b0, 2'd0, 2'd0, 64'd0, 64'd0, 256'd0, 1'b0, 1'b1, "R8");
        step(1'b1, 2'd0, 2'd0, 64'h5003, 64'h77, 256'd0, 1'b0, 1'b0, "R8");
        step(1'b1, 2'd1, 2'd0, 64'h5003, 64'h77, 256'd0, 1'b0, 1'b0, "R8");

        // R7: misaligned request leaves the reservation in place
        step(1'b0, 2'd0, 2'd0, 64'd0, 64'd0, 256'd0, 1'b0, 1'b1, "R7");
        step(1'b1, 2'd1, 2'd2, 64'h302, 64'h1, 256'd0, 1'b0, 1'b0, "R7");
        step(1'b1, 2'd1, 2'd1, 64'h302, 64'hABCD, 256'd0, 1'b0, 1'b0, "R4");

        // R8: set in same cycle as a writing store wins
        step(1'b1, 2'd0, 2'd3, 64'h400, 64'h55, 256'd0, 1'b0, 1'b1, "R8");
        step(1'b1, 2'd1, 2'd3, 64'h408, 64'h66, 256'd0, 1'b0, 1'b0, "R8");

        // R5: capability stores with tag 1 and 0
        step(1'b1, 2'd2, 2'd0, 64'h8000, 64'd0, cap_pat(64'h1234), 1'b1, 1'b0, "R5");
        step(1'b1, 2'd2, 2'd3, 64'h8020, 64'd0, cap_pat(64'h4321), 1'b0, 1'b0, "R5");

        // R6: conditional capability store without and with reservation
        step(1'b1, 2'd3, 2'd0, 64'h9000, 64'd0, cap_pat(64'h42), 1'b1, 1'b0, "R6");
        step(1'b0, 2'd0, 2'd0, 64'd0, 64'd0, 256'd0, 1'b0, 1'b1, "R6");
        step(1'b1, 2'd3, 2'd0, 64'h9000, 64'd0, cap_pat(64'h42), 1'b1, 1'b0, "R6");
        step(1'b1, 2'd3, 2'd0, 64'h9020, 64'd0, cap_pat(64'h43), 1'b1, 1'b0, "R6");
        idle("R9");
        idle("R9");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule